// File: doc/BRIEF.md
# Clocked 8-bit Serial Shift Port

This block moves one byte at a time between a processor and a serial link whose shift clock is driven from outside. Software writes the byte into a data register and then sets a start bit in the control register. Each falling edge of the external shift clock drives one bit onto the serial output. Each rising edge samples the serial input into the free end of the same register. After eight rising edges the data register holds the received byte. The hardware then clears the start bit and sets an interrupt flag, which stays set until software clears it.

The external clock and the serial input are brought into the system clock domain through a two-flop synchronizer, and clock edges are detected there. The shift clock rests high between transfers. The register bus is plain: one write strobe, one select line that chooses between control (0) and data (1), and combinational read data for the selected register. No data stream crosses the block's edge in a way that could be stalled, so no valid/ready handshake and no back-pressure rules apply. Each transfer is paced entirely by the external clock.

Top module: `serial_shift_port`

## Requirements
- R1: After reset the control register reads 0x00, the data register reads 0x00, `sout` is 1 and `irq` is 0.
- R2: With control bit 1 (order) at 0, bits leave least significant first: the k-th falling shift clock edge of a transfer (k = 0..7) presents data bit k on `sout`.
- R3: With control bit 1 at 1, bits leave most significant first: the k-th falling edge presents data bit 7-k.
- R4: Every rising shift clock edge during a transfer moves the sampled `sin` into the vacated end of the shift register. After eight edges the data register reads back the byte that was sent in the selected order.
- R5: On the 8th rising edge the hardware clears control bit 0 (start) and sets control bit 7 (flag).
- R6: Hardware never clears the flag. A control write with bit 7 = 0 clears it, and a control write with bit 7 = 1 leaves it unchanged.
- R7: `irq` is 1 exactly when the flag and control bit 6 (interrupt enable) are both 1.
- R8: When control bit 4 (output enable) is 0, `sout` stays 1 while shifting and reception go on internally.
- R9: Data register writes made while start is 1 are ignored.
- R10: Shift clock edges while start is 0 change neither the data register nor the flag.
- R11: A control write with bit 0 = 0 during a transfer stops it. The next start begins again at the first bit.
- R12: Control bits 5, 3 and 2 are stored and read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 control, 1 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| sck_in | input | 1 | External shift clock, idles high |
| sin | input | 1 | Serial data input |
| sout | output | 1 | Serial data output |
| irq | output | 1 | Interrupt request |

## Verification
The checker examines several rules on every cycle:
- the flag and start bit update on the final rising edge;
- the flag survives every event except a clearing write;
- the data register stays frozen while idle, and moves only on rising edges while busy;
- a stop write takes effect at once.

Only the bench scenarios can show the bit order seen on `sout` in both modes, the byte assembled from `sin`, output gating, and how a restart after an abort lines up.

// File: rtl/sio_pkg.sv
package sio_pkg;
  parameter int unsigned SIO_BITS = 8;

  // Software-visible control layout, bit 7 down to bit 0.
  typedef struct packed {
    logic       flag;
    logic       irq_en;
    logic       clk_en;
    logic       out_en;
    logic [1:0] clk_sel;
    logic       msb_first;
    logic       start;
  } sio_ctrl_t;
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
  parameter int unsigned W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int unsigned N = 8,
  localparam int unsigned CW = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         busy,
  input  logic         restart,
  input  logic         load,
  input  logic [N-1:0] load_val,
  input  logic         rise,
  input  logic         fall,
  input  logic         rx_bit,
  input  logic         msb_first,
  output logic [N-1:0] data,
  output logic         out_bit,
  output logic         done
);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt;
  logic          step;

  assign step = busy & rise;
  assign done = step & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data    <= '0;
      cnt     <= '0;
      out_bit <= 1'b1;
    end else begin
      if (restart)   cnt <= '0;
      else if (done) cnt <= '0;
      else if (step) cnt <= cnt + 1'b1;

      if (load)
        data <= load_val;
      else if (step)
        data <= msb_first ? {data[N-2:0], rx_bit} : {rx_bit, data[N-1:1]};

      if (busy && fall)
        out_bit <= msb_first ? data[N-1] : data[0];
    end
  end
endmodule

// File: rtl/serial_shift_port.sv
module serial_shift_port
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_sel,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       sck_in,
  input  logic       sin,
  output logic       sout,
  output logic       irq
);
  sio_ctrl_t            ctrl_q;
  logic [1:0]           sync_q;
  logic                 sck_s, sin_s, sck_prev;
  logic                 rise, fall;
  logic                 wr_ctrl, wr_data, restart, done;
  logic                 out_bit;
  logic [SIO_BITS-1:0]  data;

  sio_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sck_in, sin}), .q(sync_q)
  );

  assign sck_s = sync_q[1];
  assign sin_s = sync_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b1;
    else        sck_prev <= sck_s;
  end

  assign rise    = sck_s & ~sck_prev;
  assign fall    = ~sck_s & sck_prev;
  assign wr_ctrl = bus_wr & ~bus_sel;
  assign wr_data = bus_wr & bus_sel & ~ctrl_q.start;
  assign restart = wr_ctrl & bus_wdata[0] & ~ctrl_q.start;

  sio_shifter #(.N(SIO_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .busy(ctrl_q.start), .restart(restart),
    .load(wr_data), .load_val(bus_wdata[SIO_BITS-1:0]), .rise(rise),
    .fall(fall), .rx_bit(sin_s), .msb_first(ctrl_q.msb_first),
    .data(data), .out_bit(out_bit), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q.flag <= done | (ctrl_q.flag & ~(wr_ctrl & ~bus_wdata[7]));
      ctrl_q.start <= wr_ctrl ? bus_wdata[0] : (ctrl_q.start & ~done);
      if (wr_ctrl) begin
        ctrl_q.irq_en    <= bus_wdata[6];
        ctrl_q.clk_en    <= bus_wdata[5];
        ctrl_q.out_en    <= bus_wdata[4];
        ctrl_q.clk_sel   <= bus_wdata[3:2];
        ctrl_q.msb_first <= bus_wdata[1];
      end
    end
  end

  assign bus_rdata = bus_sel ? data : ctrl_q;
  assign sout      = ctrl_q.out_en ? out_bit : 1'b1;
  assign irq       = ctrl_q.flag & ctrl_q.irq_en;
endmodule

// File: rtl/sio_checker.sv
module sio_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       flag,
  input logic       rise,
  input logic       done,
  input logic       wr_ctrl,
  input logic       wr_data_req,
  input logic       wbit7,
  input logic       wbit0,
  input logic [7:0] data
);
  assert_done_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr_ctrl) |=> (!busy && flag));

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(wr_ctrl && !wbit7)) |=> flag);

  assert_busy_data_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rise) |=> $stable(data));

  assert_idle_data_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_data_req) |=> $stable(data));

  assert_idle_no_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !done);

  assert_stop_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !wbit0) |=> !busy);
endmodule

bind serial_shift_port sio_checker u_sio_chk (
  .clk(clk), .rst_n(rst_n), .busy(ctrl_q.start), .flag(ctrl_q.flag),
  .rise(rise), .done(done), .wr_ctrl(wr_ctrl),
  .wr_data_req(bus_wr & bus_sel), .wbit7(bus_wdata[7]),
  .wbit0(bus_wdata[0]), .data(data)
);

// File: tb/tb_serial_shift_port.sv
`timescale 1ns/1ps
module tb_serial_shift_port;
  logic       clk = 0, rst_n = 0;
  logic       bus_wr = 0, bus_sel = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic       sck_in = 1, sin = 0, sout, irq;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  serial_shift_port dut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic sel, logic [7:0] v);
    @(negedge clk); bus_sel = sel; bus_wdata = v; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_reg(logic sel, output logic [7:0] v);
    @(negedge clk); bus_sel = sel; #1 v = bus_rdata;
  endtask

  function automatic logic exp_out(logic [7:0] tx, int k, logic msb);
    return msb ? tx[7-k] : tx[k];
  endfunction

  function automatic logic [7:0] ctrl_word(logic ie, logic oe, logic msb, logic st);
    return {1'b0, ie, 1'b1, oe, 2'b00, msb, st};
  endfunction

  // One shift clock period: low phase carries the next input bit.
  task automatic sck_cycle(logic rx, output logic so);
    @(negedge clk); sck_in = 0; sin = rx;
    repeat (6) @(negedge clk);
    so = sout;
    sck_in = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic xfer(logic [7:0] tx, logic [7:0] rx, logic msb, logic oe,
                      logic ie, bit mid_wr);
    logic so; logic [7:0] v;
    wr_reg(1, tx);
    wr_reg(0, ctrl_word(ie, oe, msb, 1));
    for (int k = 0; k < 8; k++) begin
      if (mid_wr && k == 4) wr_reg(1, ~tx);
      sck_cycle(msb ? rx[7-k] : rx[k], so);
      if (oe) chk(msb ? "R3 msb order" : "R2 lsb order", {7'b0, so}, {7'b0, exp_out(tx, k, msb)});
      else    chk("R8 gated high", {7'b0, so}, 8'h01);
    end
    rd_reg(1, v);
    chk(mid_wr ? "R9 busy write ignored" : "R4 received byte", v, rx);
    rd_reg(0, v);
    chk("R5 start cleared flag set", {v[7], v[0]}, 8'h02);
    chk("R7 irq follows flag and enable", {7'b0, irq}, {7'b0, ie});
  endtask

  initial begin
    logic [7:0] v; logic so;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_reg(0, v); chk("R1 ctrl reset", v, 8'h00);
    rd_reg(1, v); chk("R1 data reset", v, 8'h00);
    chk("R1 sout reset", {7'b0, sout}, 8'h01);
    chk("R1 irq reset", {7'b0, irq}, 8'h00);

    // R12 stored fields
    wr_reg(0, 8'b0010_1100); rd_reg(0, v); chk("R12 readback", v, 8'b0010_1100);
    wr_reg(0, 8'h00);

    xfer(8'hA5, 8'h3C, 0, 1, 1, 0);
    // R6 flag sticky against write of 1, cleared by write of 0
    wr_reg(0, 8'hC0); rd_reg(0, v); chk("R6 write one keeps flag", {7'b0, v[7]}, 8'h01);
    wr_reg(0, 8'h80); chk("R7 irq off with enable 0", {7'b0, irq}, 8'h00);
    wr_reg(0, 8'h40); rd_reg(0, v); chk("R6 write zero clears flag", {7'b0, v[7]}, 8'h00);
    chk("R7 irq off with flag 0", {7'b0, irq}, 8'h00);

    xfer(8'h96, 8'hE1, 1, 1, 0, 0);
    xfer(8'h5A, 8'h81, 0, 0, 1, 0);
    xfer(8'h0F, 8'h42, 1, 1, 1, 1);

    // R10 idle clocks
    wr_reg(0, 8'h00); wr_reg(1, 8'h77);
    for (int k = 0; k < 10; k++) sck_cycle(k[0], so);
    rd_reg(1, v); chk("R10 idle data unchanged", v, 8'h77);
    rd_reg(0, v); chk("R10 idle flag clear", {7'b0, v[7]}, 8'h00);

    // R11 abort after three bits then full restart
    wr_reg(1, 8'hC3); wr_reg(0, ctrl_word(0, 1, 0, 1));
    for (int k = 0; k < 3; k++) sck_cycle(1'b1, so);
    wr_reg(0, ctrl_word(0, 1, 0, 0));
    rd_reg(0, v); chk("R11 stop clears start", {v[7], v[0]}, 8'h00);
    sck_cycle(1'b0, so);
    rd_reg(0, v); chk("R11 no flag after stop", {7'b0, v[7]}, 8'h00);
    xfer(8'h6D, 8'hB4, 0, 1, 0, 0);

    for (int n = 0; n < 20; n++) begin
      logic [7:0] t, r; logic m;
      t = 8'($urandom); r = 8'($urandom); m = 1'($urandom);
      xfer(t, r, m, 1, 1'($urandom), 0);
      wr_reg(0, 8'h00);
    end
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule